// File: doc/BRIEF.md
# Atomic Bit Test-and-Clear Unit

This block carries out a single-bit test-and-clear on a 32-bit word. One command gives the kind of target, an address or register select, and an immediate bit index. The old value of the chosen bit is copied into the carry flag. The word is then written back with only that bit forced to zero. There are four kinds of target: a word in one of two shared memory spaces (X or Y), a register operand supplied by the surrounding core, or the unit's own status register.

For memory targets the read and the write-back form one locked pair of bus accesses on a request/acknowledge bus. A lock output stays high across both accesses, so no other master can reach the memory between them. This makes the operation usable as a semaphore primitive between processors. A register target finishes in one cycle with no bus activity. A status-register target clears the chosen status bit directly. Bits 0 to 7 of the status register are the condition flags, and clearing one of them clears that flag.

Top module: `bit_tac_unit`

## Requirements
- R1: The immediate index (0 to 31) selects one bit. The word written back equals the original operand with that bit zero and every other bit unchanged.
- R2: On completion of a memory or register target, status bit 0 (carry C) holds the prior value of the selected bit.
- R3: Targets are encoded on `cmd_target` as 0 = X memory, 1 = Y memory, 2 = register, 3 = status register. A memory target makes exactly one read (`mem_we`=0) followed by exactly one write (`mem_we`=1), both to the same `mem_addr`, with `mem_space` 0 for X and 1 for Y.
- R4: `mem_lock` is high in every cycle in which `mem_req` is high. It stays high continuously from the read request until the write acknowledge, and falls only in the cycle after the write acknowledge.
- R5: `busy` is high from the cycle after a memory command is accepted until completion. `done` is a one-cycle pulse in the cycle after the write acknowledge, and `busy` is low while `done` is high.
- R6: A command presented while `busy` is high is ignored. It causes no register write, no extra bus access and no extra `done`.
- R7: A register target raises `done` and `rf_we` in the cycle after acceptance. `rf_wsel` equals the low bits of `cmd_addr`, `rf_wdata` equals the cleared operand, and `busy` and `mem_req` stay low.
- R8: A status-register target clears the selected status bit and loads C with that bit's prior value. All other status bits are unchanged. Bits 0 to 7 are the flags C, V, Z, N, I, LR, R, A in that order.
- R9: A status-register target with index 0 leaves C at zero. The clear takes priority over loading the tested value.
- R10: `sr_wr_en` loads `sr_wr_data` into the status register at the next edge. If the unit updates the status register at that same edge, the unit's update wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_target | input | 2 | Target kind (see R3) |
| cmd_addr | input | 16 | Memory address, or register select in the low bits |
| cmd_bit | input | 5 | Immediate bit index |
| cmd_operand | input | 32 | Register value, used for register targets |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_space | output | 1 | Memory space, 0 = X, 1 = Y |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Bus acknowledge |
| mem_lock | output | 1 | Bus lock across the read-modify-write |
| rf_we | output | 1 | Register write strobe |
| rf_wsel | output | 4 | Register select for the write |
| rf_wdata | output | 32 | Register write data |
| sr_wr_en | input | 1 | Load the status register |
| sr_wr_data | input | 32 | Value to load |
| status | output | 32 | Status register, carry at bit 0 |
| busy | output | 1 | Memory operation in progress |
| done | output | 1 | Completion pulse |

## Verification
Register and status-register targets show their result one cycle after acceptance. The bench drives the command at a falling edge and samples `done`, `rf_*` and `status` at the very next falling edge. A memory target with a responder inserting w wait states per access finishes 4 + 2w falling edges after the command is driven. This counts the accept edge, the read acknowledge, the responder's idle cycle and the write acknowledge. The bench checks that exact count, then confirms at the following falling edge that `done` has dropped. Lock behaviour is watched by the responder on every falling edge across each transaction.

// File: rtl/btc_pkg.sv
package btc_pkg;
    typedef enum logic [1:0] {
        TGT_XMEM = 2'd0,
        TGT_YMEM = 2'd1,
        TGT_REG  = 2'd2,
        TGT_STAT = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;

    localparam int CARRY_POS = 0;
endpackage

// File: rtl/btc_seq.sv
module btc_seq
    import btc_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 16,
    parameter int RSW = 4,
    localparam int BW = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_target,
    input  logic [AW-1:0]  cmd_addr,
    input  logic [BW-1:0]  cmd_bit,
    input  logic [DW-1:0]  cmd_operand,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_space,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic           mem_lock,
    output logic           rf_we,
    output logic [RSW-1:0] rf_wsel,
    output logic [DW-1:0]  rf_wdata,
    output logic           busy,
    output logic           done,
    output logic           upd_en,
    output logic           upd_stat,
    output logic [BW-1:0]  upd_bit,
    output logic           upd_tbit
);
    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic          space;
        logic [BW-1:0] bidx;
        logic [DW-1:0] data;
        logic          tbit;
        logic          done;
        logic          rf_we;
    } seq_s;

    seq_s seq_q, seq_d;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.rf_we = 1'b0;
        upd_en      = 1'b0;
        upd_stat    = 1'b0;
        upd_tbit    = seq_q.tbit;
        upd_bit     = seq_q.bidx;
        case (seq_q.st)
            ST_IDLE: begin
                upd_bit = cmd_bit;
                if (cmd_valid) begin
                    seq_d.bidx = cmd_bit;
                    seq_d.addr = cmd_addr;
                    case (tgt_e'(cmd_target))
                        TGT_XMEM, TGT_YMEM: begin
                            seq_d.st    = ST_READ;
                            seq_d.space = (tgt_e'(cmd_target) == TGT_YMEM);
                        end
                        TGT_REG: begin
                            seq_d.data  = cmd_operand & ~(DW'(1) << cmd_bit);
                            seq_d.tbit  = cmd_operand[cmd_bit];
                            seq_d.rf_we = 1'b1;
                            seq_d.done  = 1'b1;
                            upd_en      = 1'b1;
                            upd_tbit    = cmd_operand[cmd_bit];
                        end
                        default: begin
                            seq_d.done = 1'b1;
                            upd_en     = 1'b1;
                            upd_stat   = 1'b1;
                        end
                    endcase
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    seq_d.data = mem_rdata & ~(DW'(1) << seq_q.bidx);
                    seq_d.tbit = mem_rdata[seq_q.bidx];
                    seq_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                    upd_en     = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign mem_req   = (seq_q.st == ST_READ) || (seq_q.st == ST_WRITE);
    assign mem_we    = (seq_q.st == ST_WRITE);
    assign mem_lock  = (seq_q.st != ST_IDLE);
    assign mem_space = seq_q.space;
    assign mem_addr  = seq_q.addr;
    assign mem_wdata = seq_q.data;
    assign rf_we     = seq_q.rf_we;
    assign rf_wsel   = seq_q.addr[RSW-1:0];
    assign rf_wdata  = seq_q.data;
    assign busy      = (seq_q.st != ST_IDLE);
    assign done      = seq_q.done;

    // R4: every request carries the lock
    a_r4_lock_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);
    // R4: lock drops only after a write acknowledge
    a_r4_lock_until_wack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> $past(mem_req && mem_we && mem_ack));
    // R3: a write phase only ever follows an acknowledged read
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack));
    // R1: written word has the selected bit at zero
    a_r1_wbit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[seq_q.bidx]);
    // R5: completion is never reported while busy
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: register write never coincides with bus activity
    a_r7_reg_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !mem_req);
endmodule

// File: rtl/btc_flags.sv
module btc_flags
    import btc_pkg::*;
#(
    parameter int DW  = 32,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic          upd_stat,
    input  logic [BW-1:0] upd_bit,
    input  logic          upd_tbit,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] sr
);
    logic [DW-1:0] sr_q, sr_d;
    logic          old_bit;

    always_comb begin
        sr_d    = sr_q;
        old_bit = sr_q[upd_bit];
        if (upd_en) begin
            if (upd_stat) begin
                sr_d[upd_bit] = 1'b0;
                if (upd_bit != '0) sr_d[CARRY_POS] = old_bit;
            end else begin
                sr_d[CARRY_POS] = upd_tbit;
            end
        end else if (ld_en) begin
            sr_d = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sr = sr_q;

    // R2: carry takes the tested value for non-status targets
    a_r2_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_stat) |=> (sr_q[CARRY_POS] == $past(upd_tbit)));
    // R8: the selected status bit ends at zero
    a_r8_stat_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_stat) |=> (sr_q[$past(upd_bit)] == 1'b0));
    // R9: index 0 on the status register leaves carry clear
    a_r9_carry_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_stat && upd_bit == '0) |=> !sr_q[CARRY_POS]);
    // R10: a load is dropped when the unit updates the register
    a_r10_unit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_stat && ld_en) |=> (sr_q[DW-1:1] == $past(sr_q[DW-1:1])));
endmodule

// File: rtl/bit_tac_unit.sv
module bit_tac_unit
    import btc_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 16,
    parameter int RSW = 4,
    localparam int BW = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_target,
    input  logic [AW-1:0]  cmd_addr,
    input  logic [BW-1:0]  cmd_bit,
    input  logic [DW-1:0]  cmd_operand,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_space,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic           mem_lock,
    output logic           rf_we,
    output logic [RSW-1:0] rf_wsel,
    output logic [DW-1:0]  rf_wdata,
    input  logic           sr_wr_en,
    input  logic [DW-1:0]  sr_wr_data,
    output logic [DW-1:0]  status,
    output logic           busy,
    output logic           done
);
    logic          upd_en;
    logic          upd_stat;
    logic [BW-1:0] upd_bit;
    logic          upd_tbit;

    btc_seq #(.DW(DW), .AW(AW), .RSW(RSW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_target  (cmd_target),
        .cmd_addr    (cmd_addr),
        .cmd_bit     (cmd_bit),
        .cmd_operand (cmd_operand),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_space   (mem_space),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .mem_lock    (mem_lock),
        .rf_we       (rf_we),
        .rf_wsel     (rf_wsel),
        .rf_wdata    (rf_wdata),
        .busy        (busy),
        .done        (done),
        .upd_en      (upd_en),
        .upd_stat    (upd_stat),
        .upd_bit     (upd_bit),
        .upd_tbit    (upd_tbit)
    );

    btc_flags #(.DW(DW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_stat (upd_stat),
        .upd_bit  (upd_bit),
        .upd_tbit (upd_tbit),
        .ld_en    (sr_wr_en),
        .ld_data  (sr_wr_data),
        .sr       (status)
    );
endmodule

// File: tb/bit_tac_unit_tb.sv
module bit_tac_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_target = '0;
    logic [15:0] cmd_addr = '0;
    logic [4:0]  cmd_bit = '0;
    logic [31:0] cmd_operand = '0;
    logic        mem_req, mem_we, mem_space, mem_lock;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        rf_we;
    logic [3:0]  rf_wsel;
    logic [31:0] rf_wdata;
    logic        sr_wr_en = 1'b0;
    logic [31:0] sr_wr_data = '0;
    logic [31:0] status;
    logic        busy, done;

    int checks = 0;
    int fails = 0;
    int ws = 0;
    int wcnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int viol = 0;
    int cyc = 0;
    logic lock_prev = 1'b0;
    logic wack_prev = 1'b0;
    logic [31:0] mem [2][16];

    always #2 clk = ~clk;

    bit_tac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_target(cmd_target),
        .cmd_addr(cmd_addr), .cmd_bit(cmd_bit), .cmd_operand(cmd_operand),
        .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_lock(mem_lock),
        .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata), .sr_wr_en(sr_wr_en),
        .sr_wr_data(sr_wr_data), .status(status), .busy(busy), .done(done)
    );

    // bus responder with wait states, also watching the lock
    always @(negedge clk) begin
        if (mem_req && !mem_lock) viol++;
        if (lock_prev && !mem_lock && !wack_prev) viol++;
        lock_prev = mem_lock;
        wack_prev = 1'b0;
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt == ws) begin
                mem_ack = 1'b1;
                wcnt = 0;
                if (mem_we) begin
                    mem[mem_space][mem_addr[3:0]] = mem_wdata;
                    wr_cnt++;
                    wack_prev = 1'b1;
                end else begin
                    mem_rdata = mem[mem_space][mem_addr[3:0]];
                    rd_cnt++;
                end
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] tgt, input logic [15:0] a, input logic [4:0] b,
                         input logic [31:0] op);
        cmd_valid = 1'b1; cmd_target = tgt; cmd_addr = a; cmd_bit = b; cmd_operand = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic load_sr(input logic [31:0] v);
        sr_wr_en = 1'b1; sr_wr_data = v;
        @(negedge clk);
        sr_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R5 reset idle", {30'd0, busy, done}, 32'd0);
        chk(!mem_req && !mem_lock && !rf_we, "R4 reset bus quiet", {29'd0, mem_req, mem_lock, rf_we}, 32'd0);
        chk(status == 32'd0, "R8 reset status", status, 32'd0);
    endtask

    task automatic t_mem(input logic [1:0] tgt, input logic [3:0] a, input logic [4:0] b,
                         input logic [31:0] init, input int w);
        int lat;
        logic [31:0] exp;
        logic sp;
        logic [31:0] other;
        sp = tgt[0];
        ws = w;
        mem[sp][a] = init;
        other = mem[!sp][a];
        rd_cnt = 0; wr_cnt = 0; viol = 0;
        exp = init & ~(32'd1 << b);
        issue(tgt, {12'd0, a}, b, 32'hDEAD_BEEF);
        chk(busy == 1'b1, "R5 busy after accept", {31'd0, busy}, 32'd1);
        wait_done(lat);
        chk(lat == 4 + 2 * w, "R5 done latency", lat, 4 + 2 * w);
        chk(!busy, "R5 busy low at done", {31'd0, busy}, 32'd0);
        chk(mem[sp][a] == exp, "R1 written word", mem[sp][a], exp);
        chk(mem[!sp][a] == other, "R3 other space untouched", mem[!sp][a], other);
        chk(status[0] == init[b], "R2 carry from memory", {31'd0, status[0]}, {31'd0, init[b]});
        chk(rd_cnt == 1 && wr_cnt == 1, "R3 one read one write", rd_cnt * 16 + wr_cnt, 17);
        @(negedge clk);
        chk(viol == 0, "R4 lock held", viol, 0);
        chk(!done && !mem_lock, "R5 done single pulse", {30'd0, done, mem_lock}, 32'd0);
    endtask

    task automatic t_reg(input logic [3:0] sel, input logic [4:0] b, input logic [31:0] op);
        logic [31:0] exp;
        exp = op & ~(32'd1 << b);
        rd_cnt = 0;
        issue(2'd2, {12'hAB0, sel}, b, op);
        chk(done && rf_we && !busy, "R7 one-cycle completion", {29'd0, done, rf_we, busy}, 32'd6);
        chk(rf_wdata == exp, "R7 register data", rf_wdata, exp);
        chk(rf_wsel == sel, "R7 register select", {28'd0, rf_wsel}, {28'd0, sel});
        chk(status[0] == op[b], "R2 carry from register", {31'd0, status[0]}, {31'd0, op[b]});
        @(negedge clk);
        chk(rd_cnt == 0 && !rf_we, "R7 no bus activity", rd_cnt, 0);
    endtask

    task automatic t_sr(input logic [31:0] init, input logic [4:0] b, input logic [31:0] exp, input string tag);
        load_sr(init);
        chk(status == init, "R10 status load", status, init);
        issue(2'd3, 16'd0, b, 32'd0);
        chk(done && !busy, "R8 status one cycle", {30'd0, done, busy}, 32'd2);
        chk(status == exp, tag, status, exp);
    endtask

    task automatic t_ignore();
        int lat;
        int dcnt;
        ws = 1; rd_cnt = 0; wr_cnt = 0;
        mem[0][9] = 32'h0000_0F00;
        issue(2'd0, 16'd9, 5'd8, 32'd0);
        issue(2'd2, 16'd2, 5'd1, 32'hFFFF_FFFF);
        chk(!rf_we, "R6 command ignored while busy", {31'd0, rf_we}, 32'd0);
        dcnt = 0;
        lat = 0;
        while (busy && lat < 60) begin
            @(negedge clk);
            lat++;
            if (rf_we) dcnt = dcnt + 16;
        end
        if (done) dcnt++;
        @(negedge clk);
        if (done) dcnt++;
        chk(dcnt == 1, "R6 single completion", dcnt, 1);
        chk(mem[0][9] == 32'h0000_0E00, "R6 original command result", mem[0][9], 32'h0000_0E00);
        chk(rd_cnt == 1 && wr_cnt == 1, "R6 no extra access", rd_cnt * 16 + wr_cnt, 17);
    endtask

    task automatic t_prio();
        load_sr(32'h0000_00FF);
        sr_wr_en = 1'b1; sr_wr_data = 32'h0;
        issue(2'd3, 16'd0, 5'd2, 32'd0);
        sr_wr_en = 1'b0;
        chk(status == 32'h0000_00FB, "R10 unit update wins", status, 32'h0000_00FB);
        load_sr(32'h1234_5678);
        chk(status == 32'h1234_5678, "R10 plain load", status, 32'h1234_5678);
    endtask

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 16; i++) mem[s][i] = 32'h5A5A_0000 + 32'(s * 16 + i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mem(2'd0, 4'd3, 5'd5, 32'hA5A5_FFFF, 0);
        t_mem(2'd1, 4'd3, 5'd31, 32'h7000_0001, 2);
        t_mem(2'd1, 4'd7, 5'd0, 32'h0000_0001, 1);
        t_reg(4'd5, 5'd0, 32'h0000_0011);
        t_reg(4'd12, 5'd17, 32'hFFFD_FFFF);
        t_sr(32'h0000_00FA, 5'd3, 32'h0000_00F3, "R8 clear N flag");
        t_sr(32'h0000_000F, 5'd0, 32'h0000_000E, "R9 clear carry wins");
        t_sr(32'h0000_0041, 5'd6, 32'h0000_0001, "R8 clear R flag");
        t_sr(32'h0000_0021, 5'd4, 32'h0000_0020, "R8 clear I flag already zero");
        t_sr(32'h8000_0000, 5'd31, 32'h0000_0001, "R8 upper status bit");
        t_ignore();
        t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end
endmodule